// File: doc/BRIEF.md
# Minor Gauge Half-Range Decoder

This block turns a 10-bit data word into drive settings for one single-coil minor gauge. The coil hangs between two output amplifiers, A and B. The low eight bits form a scale code from 0 to 255. Bit 7 picks the half of the range. In the lower half, A follows the converter level and B is held at the high rail. In the upper half the two roles swap, so the coil voltage changes polarity around mid-scale.

Bits 6..0 set a 7-bit converter level. That level is inverted in the upper half, so the ramp mirrors around the centre. Codes 0 and 255 then give the two opposite full-scale deflections, and codes 127 and 128 sit on either side of zero.

Bits 9..8 are guard bits and must be zero for the drive to be enabled. The group enable is sampled together with the word. All outputs are registered and change only on a load strobe.

Top module: `minor_gauge_decoder`

## Requirements
- R1: While rst_ni is low, and after reset until the first load, both selects are OFF (2'b00) and dac_code_o is 0.
- R2: On a load with bit 7 = 0, guard bits zero and grp_en_i = 1, dac_code_o becomes data_i[6:0] on the next clock edge.
- R3: On an enabled load with bit 7 = 1, dac_code_o becomes the bitwise inverse of data_i[6:0].
- R4: On an enabled load with a scale code below 128, amp_a_sel_o becomes DAC (2'b10) and amp_b_sel_o becomes HIGH (2'b01).
- R5: On an enabled load with a scale code of 128 or above, amp_a_sel_o becomes HIGH (2'b01) and amp_b_sel_o becomes DAC (2'b10).
- R6: On a load where data_i[9:8] is not 2'b00, both selects become OFF (2'b00) and dac_code_o becomes 0, whatever grp_en_i is.
- R7: On a load with grp_en_i = 0, both selects become OFF and dac_code_o becomes 0.
- R8: Without load_i, all outputs hold their values, whatever data_i and grp_en_i do.
- R9: The ends of the scale map as follows:
  - code 0: A = DAC, B = HIGH, dac_code_o = 0.
  - code 127: A = DAC, B = HIGH, dac_code_o = 127.
  - code 128: A = HIGH, B = DAC, dac_code_o = 127.
  - code 255: A = HIGH, B = DAC, dac_code_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Strobe that captures a new data word |
| data_i | input | 10 | Data word: guard bits 9..8, half bit 7, level bits 6..0 |
| grp_en_i | input | 1 | Minor group enable, sampled on load |
| amp_a_sel_o | output | 2 | Amplifier A source: 00 OFF, 01 HIGH, 10 DAC |
| amp_b_sel_o | output | 2 | Amplifier B source: 00 OFF, 01 HIGH, 10 DAC |
| dac_code_o | output | 7 | Converter level after the half-range inversion |

## Verification
The hardest case to reach is the mid-scale crossing. Codes 127 and 128 give the same converter level, and the only difference between them is which amplifier sits at the rail. The stimulus therefore sweeps all 256 scale codes in ascending order with the guard bits clear, so that every adjacent pair, including the crossing, is checked.

Enabled loads are interleaved with words carrying each non-zero guard pattern and with loads where the enable is dropped. Between loads, data_i is driven with junk while load_i stays low, to show that nothing reaches the outputs.

// File: rtl/minor_gauge_pkg.sv
package minor_gauge_pkg;
  typedef enum logic [1:0] {
    SRC_OFF  = 2'b00,
    SRC_HIGH = 2'b01,
    SRC_DAC  = 2'b10
  } amp_src_e;
endpackage

// File: rtl/minor_code_split.sv
module minor_code_split #(
  parameter int DATA_W  = 10,
  parameter int LEVEL_W = 7
) (
  input  logic [DATA_W-1:0]  word_i,
  output logic               upper_half_o,
  output logic [LEVEL_W-1:0] level_o,
  output logic               guard_ok_o
);
  localparam int HALF_BIT = LEVEL_W;
  localparam int GUARD_W  = DATA_W - LEVEL_W - 1;

  assign upper_half_o = word_i[HALF_BIT];
  // mirror the ramp in the upper half
  assign level_o = word_i[LEVEL_W-1:0] ^ {LEVEL_W{word_i[HALF_BIT]}};

  generate
    if (GUARD_W > 0) begin : g_guard
      assign guard_ok_o = ~|word_i[DATA_W-1:HALF_BIT+1];
    end else begin : g_no_guard
      assign guard_ok_o = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/minor_amp_mux.sv
module minor_amp_mux
  import minor_gauge_pkg::*;
(
  input  logic     upper_half_i,
  input  logic     enable_i,
  output amp_src_e amp_a_o,
  output amp_src_e amp_b_o
);
  always_comb begin
    if (!enable_i) begin
      amp_a_o = SRC_OFF;
      amp_b_o = SRC_OFF;
    end else if (upper_half_i) begin
      amp_a_o = SRC_HIGH;
      amp_b_o = SRC_DAC;
    end else begin
      amp_a_o = SRC_DAC;
      amp_b_o = SRC_HIGH;
    end
  end
endmodule

// File: rtl/minor_gauge_decoder.sv
module minor_gauge_decoder
  import minor_gauge_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int LEVEL_W = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic               grp_en_i,
  output logic [1:0]         amp_a_sel_o,
  output logic [1:0]         amp_b_sel_o,
  output logic [LEVEL_W-1:0] dac_code_o
);
  logic               upper_half;
  logic [LEVEL_W-1:0] level;
  logic               guard_ok;
  logic               drive_en;
  amp_src_e           src_a, src_b;

  minor_code_split #(.DATA_W(DATA_W), .LEVEL_W(LEVEL_W)) u_split (
    .word_i      (data_i),
    .upper_half_o(upper_half),
    .level_o     (level),
    .guard_ok_o  (guard_ok)
  );

  assign drive_en = guard_ok & grp_en_i;

  minor_amp_mux u_mux (
    .upper_half_i(upper_half),
    .enable_i    (drive_en),
    .amp_a_o     (src_a),
    .amp_b_o     (src_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      amp_a_sel_o <= SRC_OFF;
      amp_b_sel_o <= SRC_OFF;
      dac_code_o  <= '0;
    end else if (load_i) begin
      amp_a_sel_o <= src_a;
      amp_b_sel_o <= src_b;
      dac_code_o  <= drive_en ? level : '0;
    end
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(amp_a_sel_o) && $stable(amp_b_sel_o) && $stable(dac_code_o)));

  p_guard_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && data_i[DATA_W-1:LEVEL_W+1] != '0) |=>
      (amp_a_sel_o == SRC_OFF && amp_b_sel_o == SRC_OFF && dac_code_o == '0));

  p_group_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !grp_en_i) |=> (amp_a_sel_o == SRC_OFF && amp_b_sel_o == SRC_OFF));

  p_low_half_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && grp_en_i && data_i[DATA_W-1:LEVEL_W] == '0) |=>
      (amp_a_sel_o == SRC_DAC && amp_b_sel_o == SRC_HIGH && dac_code_o == $past(data_i[LEVEL_W-1:0])));

  p_up_half_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && grp_en_i && data_i[DATA_W-1:LEVEL_W] == 1) |=>
      (amp_a_sel_o == SRC_HIGH && amp_b_sel_o == SRC_DAC && dac_code_o == ~$past(data_i[LEVEL_W-1:0])));

  p_one_rail_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (amp_a_sel_o != SRC_OFF) |-> (amp_b_sel_o != SRC_OFF && amp_b_sel_o != amp_a_sel_o));
endmodule

// File: tb/minor_gauge_decoder_tb_top.sv
module minor_gauge_decoder_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       load_i = 1'b0;
  logic [9:0] data_i = '0;
  logic       grp_en_i = 1'b0;
  logic [1:0] amp_a_sel_o, amp_b_sel_o;
  logic [6:0] dac_code_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [10:0] exp_q[$];
  logic [10:0] last_exp = '0;

  always #10 clk_i = ~clk_i;

  minor_gauge_decoder dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .data_i(data_i),
    .grp_en_i(grp_en_i), .amp_a_sel_o(amp_a_sel_o), .amp_b_sel_o(amp_b_sel_o),
    .dac_code_o(dac_code_o)
  );

  // expected {a_sel, b_sel, dac}
  function automatic logic [10:0] model(logic [9:0] d, logic en);
    if (!en || d[9:8] != 2'b00) return 11'd0;
    if (d[7]) return {2'b01, 2'b10, ~d[6:0]};
    return {2'b10, 2'b01, d[6:0]};
  endfunction

  function automatic string tag(logic [9:0] d, logic en);
    if (d[9:8] != 0) return "R6";
    if (!en) return "R7";
    if (d[7:0] == 0 || d[7:0] == 127 || d[7:0] == 128 || d[7:0] == 255) return "R9";
    return d[7] ? "R3/R5" : "R2/R4";
  endfunction

  task automatic check(string req, logic [10:0] exp);
    logic [10:0] act = {amp_a_sel_o, amp_b_sel_o, dac_code_o};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic load_word(logic [9:0] d, logic en);
    @(negedge clk_i);
    data_i = d; grp_en_i = en; load_i = 1'b1;
    exp_q.push_back(model(d, en));
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  task automatic idle_junk(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      data_i = 10'($urandom); grp_en_i = 1'($urandom);
      check("R8", last_exp);
    end
  endtask

  // monitor: pops one expected item per captured load
  initial begin
    forever begin
      @(posedge clk_i);
      if (rst_ni && load_i) begin
        @(negedge clk_i);
        if (exp_q.size() == 0) begin
          total++; bad++;
          $display("FAIL scoreboard act=%h exp=none", {amp_a_sel_o, amp_b_sel_o, dac_code_o});
        end else begin
          last_exp = exp_q.pop_front();
          check(tag(data_i, grp_en_i), last_exp);
        end
      end
    end
  end

  initial begin
    #5;
    check("R1", 11'd0);
    repeat (3) @(negedge clk_i);
    check("R1", 11'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", 11'd0);
    // R9 ends and mid crossing
    load_word(10'd0, 1'b1);
    load_word(10'd127, 1'b1);
    load_word(10'd128, 1'b1);
    load_word(10'd255, 1'b1);
    idle_junk(4);
    // full sweep R2/R3/R4/R5
    for (int c = 0; c < 256; c++) load_word(10'(c), 1'b1);
    idle_junk(3);
    // guard bits R6
    for (int g = 1; g < 4; g++) begin
      load_word({2'(g), 8'h35}, 1'b1);
      idle_junk(2);
      load_word(10'h0b5, 1'b1);
      load_word({2'(g), 8'hc2}, 1'b0);
    end
    // group enable R7
    load_word(10'h042, 1'b0);
    idle_junk(2);
    load_word(10'h0c0, 1'b1);
    load_word(10'h0ff, 1'b0);
    load_word(10'h07f, 1'b1);
    idle_junk(5);
    repeat (2) @(negedge clk_i);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard act=%0d exp=0 pending", exp_q.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule